// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block merges the enable mask and the pending status of three interrupt sources into one byte-wide register. Two of the sources are edge-type: an external trigger pin and the output of pacer counter 1. Their rising edges are caught and held in sticky pending bits. The third source is the DAC FIFO condition. It is level-type, so its status bit simply follows the live condition.

A read returns the pending status. A write loads the enable mask. Writing a zero into an edge bit also clears that bit's latched edge. The usual service sequence is to read the status, write the enable byte back with the serviced bits cleared, and then write it again with those bits set to re-arm them. A single active-high request output is the OR of every pending bit whose enable is set.

Top module: `irq_src_reg`

## Requirements
- R1: Read bit positions are fixed: bit 0 is the external trigger, bit 2 is the DAC FIFO condition and bit 5 is counter 1. All other bits are status-free.
- R2: A rising edge on the external trigger, seen while enable bit 0 is set, sets pending bit 0. The bit then stays set until it is acknowledged.
- R3: A rising edge on the counter 1 output, seen while enable bit 5 is set, sets pending bit 5. The bit then stays set until it is acknowledged.
- R4: Read bit 2 equals the present FIFO condition in every cycle, whatever the enable mask holds.
- R5: Read bits 1, 3, 4, 6 and 7 are always 0. Writing ones to those positions has no effect on the read value or on the request.
- R6: A write with bit 0 (or bit 5) at 0 clears that latched edge in the cycle of the write. The clear wins over an edge that arrives in the same cycle.
- R7: An edge that arrives while its enable bit is 0 is not recorded.
- R8: The request output is high exactly when some read bit is 1 and its enable bit is 1. The enable bit in force is the one written on or before the last clock edge.
- R9: A held-high edge source does not set its bit again after acknowledgement. A new rising edge is required.
- R10: A synchronous active-low reset clears every enable and every latched edge, so the request output is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the enable byte |
| wr_data | input | 8 | Enable mask. A 0 in an edge bit also acknowledges that bit |
| rd_data | output | 8 | Pending status byte |
| ext_trig_in | input | 1 | External trigger, edge-type |
| fifo_cond_in | input | 1 | DAC FIFO condition, level-type |
| cnt1_out_in | input | 1 | Counter 1 output, edge-type |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit register with 6 status bits. Those values cover both kinds of unused position, the status-free holes at bits 1, 3 and 4 and the always-zero top bits 7:6. Together with the fixed source positions, they expose the whole decode. The vector walk drives acknowledge-and-re-arm sequences, level bits kept while their enable is off, and writes of all ones. The directed tests cover an acknowledge that lands in the same cycle as a new edge, reset while bits are pending, and sources already high when enabled.

// File: rtl/irqsr_pkg.sv
// Package: shared source positions and source-kind decode for the
// interrupt source register. Positions are fixed because software decodes them.
package irqsr_pkg;

    localparam int EXT_POS  = 0;
    localparam int FIFO_POS = 2;
    localparam int CNT_POS  = 5;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_EDGE  = 2'd1,
        SRC_LEVEL = 2'd2
    } src_kind_e;

    // Kind of source at a bit position; positions beyond the status width are empty
    function automatic src_kind_e src_kind(input int pos, input int stat_w);
        if (pos >= stat_w)
            return SRC_NONE;
        else if (pos == EXT_POS || pos == CNT_POS)
            return SRC_EDGE;
        else if (pos == FIFO_POS)
            return SRC_LEVEL;
        else
            return SRC_NONE;
    endfunction

    // Mask of positions that hold an enable bit
    function automatic logic [7:0] impl_mask(input int stat_w);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < 8; i++)
            if (src_kind(i, stat_w) != SRC_NONE)
                m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqsr_edge_det.sv
// Rising-edge detector. Assumes sig_in is already synchronous to clk.
// Reset treats the previous value as low.
module irqsr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);

    logic prev_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sig_in;
    end

    // Pulse for one cycle when the level goes from low to high
    assign rise_o = sig_in & ~prev_q;

endmodule

// File: rtl/irqsr_edge_latch.sv
// Sticky pending bit for one edge-type source. It sets on an edge only while
// enabled. An acknowledge clears it and wins over a coincident edge.
module irqsr_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic en_i,
    input  logic ack_i,
    output logic pend_o
);

    logic pend_q;

    // Clear on acknowledge, else capture an enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (ack_i)
            pend_q <= 1'b0;
        else if (en_i && rise_i)
            pend_q <= 1'b1;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_src_reg.sv
// Combined interrupt enable and status register. A write loads the enable
// mask, and a 0 in an edge bit acknowledges that bit. A read returns the
// pending status. The request output is the OR of pending bits whose enable
// is set. Assumes every source input is synchronous to clk.
module irq_src_reg #(
    parameter int REG_W  = 8,
    parameter int STAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ext_trig_in,
    input  logic             fifo_cond_in,
    input  logic             cnt1_out_in,
    output logic             irq
);
    import irqsr_pkg::*;

    localparam logic [REG_W-1:0] EN_MASK = REG_W'(impl_mask(STAT_W));

    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] status;

    // Enable mask register; unused positions stay 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en)
            en_q <= wr_data & EN_MASK;
    end

    // Per-bit status: an edge latch, a live level, or a constant 0
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (src_kind(b, STAT_W) == SRC_EDGE) begin : g_edge
            logic src_w;
            logic rise_w;
            assign src_w = (b == EXT_POS) ? ext_trig_in : cnt1_out_in;
            irqsr_edge_det i_det (
                .clk    (clk),
                .rst_n  (rst_n),
                .sig_in (src_w),
                .rise_o (rise_w)
            );
            irqsr_edge_latch i_lat (
                .clk    (clk),
                .rst_n  (rst_n),
                .rise_i (rise_w),
                .en_i   (en_q[b]),
                .ack_i  (wr_en & ~wr_data[b]),
                .pend_o (status[b])
            );
        end else if (src_kind(b, STAT_W) == SRC_LEVEL) begin : g_level
            assign status[b] = fifo_cond_in;
        end else begin : g_none
            assign status[b] = 1'b0;
        end
    end

    assign rd_data = status;

    // Request output: any pending bit with its enable set
    assign irq = |(status & en_q);

endmodule

// File: rtl/irq_src_reg_chk.sv
// Checker for irq_src_reg. It watches the ports only and is bound to every instance.
module irq_src_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       ext_trig_in,
    input logic       fifo_cond_in,
    input logic       cnt1_out_in,
    input logic       irq
);

    // R5
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 8'hDA) == 8'h00);

    // R4
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] == fifo_cond_in);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0]) |=> !rd_data[0]);

    // R6
    ack_clear_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[5]) |=> !rd_data[5]);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !(wr_en && !wr_data[0])) |=> rd_data[0]);

    // R8
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data & 8'h25) == 8'h00) |=> !irq);

    // R8
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data != 8'h00));

endmodule

bind irq_src_reg irq_src_reg_chk i_chk (.*);

// File: tb/test_irq_src_reg.sv
module test_irq_src_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ext_trig_in = 1'b0;
    logic       fifo_cond_in = 1'b0;
    logic       cnt1_out_in = 1'b0;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    irq_src_reg i_irq_src_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .ext_trig_in  (ext_trig_in),
        .fifo_cond_in (fifo_cond_in),
        .cnt1_out_in  (cnt1_out_in),
        .irq          (irq)
    );

    // Vector: {wr_en, wr_data, ext, fifo, cnt, exp_rd, exp_irq}
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 8'h25, 3'b000, 8'h00, 1'b0}, // R10 enable all, nothing pending
        {1'b0, 8'h00, 3'b100, 8'h01, 1'b1}, // R2 ext edge latches
        {1'b0, 8'h00, 3'b110, 8'h05, 1'b1}, // R1 R4 fifo level at bit 2
        {1'b1, 8'h24, 3'b110, 8'h04, 1'b1}, // R6 ack ext, fifo still asks
        {1'b1, 8'h21, 3'b110, 8'h04, 1'b0}, // R9 R8 held-high ext not relatched; fifo masked
        {1'b0, 8'h00, 3'b001, 8'h20, 1'b1}, // R3 counter edge latches
        {1'b0, 8'h00, 3'b101, 8'h21, 1'b1}, // R2 new ext edge
        {1'b1, 8'hFF, 3'b101, 8'h21, 1'b1}, // R5 ones to unused bits ignored
        {1'b1, 8'h00, 3'b101, 8'h00, 1'b0}, // R6 ack both
        {1'b0, 8'h00, 3'b010, 8'h04, 1'b0}, // R4 level shows while disabled
        {1'b0, 8'h00, 3'b111, 8'h04, 1'b0}, // R7 disabled edges dropped
        {1'b1, 8'h25, 3'b111, 8'h04, 1'b1}, // R9 enabling with high inputs: no edge
        {1'b0, 8'h00, 3'b000, 8'h00, 1'b0}  // R4 level drops
    };

    task automatic check(input string req, input logic [7:0] exp_rd, input logic exp_irq);
        checks++;
        if (rd_data !== exp_rd || irq !== exp_irq) begin
            failures++;
            $display("FAIL %s rd=%02h irq=%0b expected rd=%02h irq=%0b",
                     req, rd_data, irq, exp_rd, exp_irq);
        end
    endtask

    // Drive one cycle of inputs, let one edge pass, and sample after it
    task automatic step(input logic we, input logic [7:0] wd,
                        input logic e, input logic f, input logic c);
        wr_en = we; wr_data = wd;
        ext_trig_in = e; fifo_cond_in = f; cnt1_out_in = c;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #1600000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk);
        #2;
        check("R10", 8'h00, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20], VEC[i][19:12], VEC[i][11], VEC[i][10], VEC[i][9]);
            check($sformatf("vec%0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // R6 ack and new edge in the same cycle: ack wins
        step(1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
        check("R6", 8'h00, 1'b0);

        // R6 re-enabling after an ack that dropped an edge gives nothing
        step(1'b1, 8'h01, 1'b1, 1'b0, 1'b0);
        check("R6", 8'h00, 1'b0);

        // R5 R1 all sources active, exact bit pattern
        step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
        check("R5", 8'h25, 1'b1);

        // R10 reset with bits pending clears latches and enables
        rst_n = 1'b0;
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R10", 8'h04, 1'b0);

        // R7 edge after reset with enables clear is dropped
        step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
        check("R7", 8'h04, 1'b0);

        // R8 enabling only the level source raises the request
        step(1'b1, 8'h04, 1'b0, 1'b1, 1'b0);
        check("R8", 8'h04, 1'b1);

        // R3 counter edge with only its own enable set
        step(1'b1, 8'h20, 1'b0, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R3", 8'h20, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule